// File: doc/BRIEF.md
# Task State Segment Loader

This block fetches the register image of an incoming task from a task state segment in memory. It runs as one phase of a hardware task switch. A pulse on `start` latches the segment base, the descriptor type and the paging-enable bit. The sequencer then walks the segment through a request/acknowledge memory port, one read at a time. Each read is either 2 or 4 bytes wide. The values arrive in a private shadow bank, and on success they are published to the output registers in one step.

Two segment layouts exist, a 16-bit one and a 32-bit one. They differ in read offsets, read widths and the fields they contain, and each applies its own rules for filling the upper bits of the loaded registers. When `done` pulses, every read of the new state has finished, so the surrounding logic may then begin writing the outgoing task's state. A memory error ends the sequence early, raises `fault` and leaves the published outputs as they were.

Top module: `tss_loader`

## Requirements
- R1: A `desc_type` of 3 or less selects the 16-bit layout. It issues exactly 15 reads, all 2 bytes wide (`mem_wide`=0), at offsets 14, 16, 18, … 42 in that order.
- R2: In the 16-bit layout, `ip_out` takes the low half-word read at offset 14 and `flags_out` the one read at offset 16. Both are zero-extended.
- R3: In the 16-bit layout, the general registers come from offsets 18..32. Slot i of `gpr_out` (bits 32i+31:32i, i=0..7) takes offset 18+2i, with 16'hFFFF placed in its upper half.
- R4: In the 16-bit layout, `sel_out` slots 0..3 (bits 16i+15:16i) come from offsets 34, 36, 38, 40, and slot 6 comes from offset 42. Slots 4 and 5 are 0, and `ptb_out` and `trap_out` are 0.
- R5: In the 32-bit layout with `paging_en`=1, the first read is 4 bytes at offset 0x1C and lands in `ptb_out`. With `paging_en`=0 that read is not issued and `ptb_out` is 0.
- R6: In the 32-bit layout, 4-byte reads at offsets 0x20..0x44 in steps of 4 fill `ip_out`, `flags_out` and `gpr_out` slots 0..7, in that order.
- R7: In the 32-bit layout, 2-byte reads at offsets 0x48..0x64 in steps of 4 fill `sel_out` slots 0..6 and then `trap_out`. Each takes the low 16 bits of `mem_rdata`.
- R8: `mem_addr` is the base latched at `start` plus the offset, taken modulo 2^32. While `mem_req` waits for `mem_ack` or `mem_err`, `mem_addr` and `mem_wide` hold steady.
- R9: `mem_err` on an outstanding read ends the sequence. It pulses `fault` for one cycle, issues no further read, leaves every output register unchanged, and returns the block to idle.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle in which the one-cycle `done` pulse is high. The output registers change only in that cycle, after the last read has been acknowledged.
- R11: A `start` pulse while `busy` is high has no effect. The running sequence keeps its base and layout, and only one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load (accepted only when idle) |
| seg_base | input | 32 | Linear base address of the segment |
| desc_type | input | 4 | Descriptor type; 0..3 selects the 16-bit layout |
| paging_en | input | 1 | Paging enabled; gates the page-table base read |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 32 | Read address |
| mem_wide | output | 1 | 1 = 4-byte read, 0 = 2-byte read |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_err | input | 1 | Read failed, request complete |
| mem_rdata | input | 32 | Read data, low bytes used for 2-byte reads |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: outputs updated, all reads finished |
| fault | output | 1 | One-cycle pulse: sequence aborted on memory error |
| ip_out | output | 32 | New instruction pointer |
| flags_out | output | 32 | New flags |
| gpr_out | output | 256 | Eight general registers, slot 0 in the low bits |
| sel_out | output | 112 | Seven selectors: ES, CS, SS, DS, FS, GS, LDT |
| ptb_out | output | 32 | New page-table base |
| trap_out | output | 16 | Debug-trap word |

## Verification
The hardest situation to reach from the ports is the error abort. A correct abort must keep the outputs from the earlier load, so the fault has to strike in the middle of a multi-read sequence after the outputs already hold known non-zero data. The bench first completes a full 32-bit load. It then arms its memory responder to answer the sixth read of the next load with an error, and compares every output against the values it held before. A second hard case is a `start` that arrives while a read is stalled. The responder adds latency so that the restart pulse, which carries a different base and layout, lands mid-sequence, and the bench then checks the logged address stream against the original base alone.

// File: rtl/tss_loader.sv
module tss_loader #(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  seg_base,
  input  logic [3:0]     desc_type,
  input  logic           paging_en,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_wide,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [31:0]    mem_rdata,
  output logic           busy,
  output logic           done,
  output logic           fault,
  output logic [31:0]    ip_out,
  output logic [31:0]    flags_out,
  output logic [255:0]   gpr_out,
  output logic [111:0]   sel_out,
  output logic [31:0]    ptb_out,
  output logic [15:0]    trap_out
);
  localparam int LAST16 = 14;
  localparam int LAST32 = 18;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_SAVE} st_t;
  st_t state;

  logic [AW-1:0] base_q;
  logic          fmt16;
  logic [4:0]    step;
  logic [4:0]    slot;
  logic [7:0]    ofs;
  logic          last;
  logic [2:0]    gpr_i, sel_i;
  logic [15:0]   rd16;

  logic [31:0]  sh_ip, sh_fl, sh_ptb;
  logic [255:0] sh_gpr;
  logic [111:0] sh_sel;
  logic [15:0]  sh_trap;

  assign slot   = fmt16 ? ((step == 5'(LAST16)) ? 5'd17 : step + 5'd1) : step;
  assign ofs    = fmt16 ? 8'(8'd14 + {2'b0, step, 1'b0}) : 8'(8'd28 + {1'b0, step, 2'b0});
  assign last   = fmt16 ? (step == 5'(LAST16)) : (step == 5'(LAST32));
  assign gpr_i  = 3'(slot - 5'd3);
  assign sel_i  = 3'(slot - 5'd11);
  assign rd16   = mem_rdata[15:0];

  assign mem_req  = (state == S_READ);
  assign mem_addr = base_q + AW'(ofs);
  assign mem_wide = !fmt16 && (step <= 5'd10);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base_q <= '0; fmt16 <= 1'b0; step <= '0;
      done <= 1'b0; fault <= 1'b0;
      sh_ip <= '0; sh_fl <= '0; sh_ptb <= '0; sh_gpr <= '0; sh_sel <= '0; sh_trap <= '0;
      ip_out <= '0; flags_out <= '0; gpr_out <= '0; sel_out <= '0; ptb_out <= '0; trap_out <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          base_q <= seg_base;
          fmt16  <= (desc_type <= 4'd3);
          step   <= ((desc_type <= 4'd3) || paging_en) ? 5'd0 : 5'd1;
          sh_ip <= '0; sh_fl <= '0; sh_ptb <= '0; sh_gpr <= '0; sh_sel <= '0; sh_trap <= '0;
          state  <= S_READ;
        end
        S_READ: if (mem_err) begin
          fault <= 1'b1;
          state <= S_IDLE;
        end else if (mem_ack) begin
          if (slot == 5'd0)
            sh_ptb <= mem_rdata;
          else if (slot == 5'd1)
            sh_ip <= fmt16 ? {16'h0, rd16} : mem_rdata;
          else if (slot == 5'd2)
            sh_fl <= fmt16 ? {16'h0, rd16} : mem_rdata;
          else if (slot <= 5'd10)
            sh_gpr[32*gpr_i +: 32] <= fmt16 ? {16'hFFFF, rd16} : mem_rdata;
          else if (slot <= 5'd17)
            sh_sel[16*sel_i +: 16] <= rd16;
          else
            sh_trap <= rd16;
          if (last) state <= S_SAVE;
          else      step  <= step + 5'd1;
        end
        S_SAVE: begin
          ip_out <= sh_ip; flags_out <= sh_fl; gpr_out <= sh_gpr;
          sel_out <= sh_sel; ptb_out <= sh_ptb; trap_out <= sh_trap;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tss_loader_chk.sv
module tss_loader_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         mem_req,
  input logic [31:0]  mem_addr,
  input logic         mem_wide,
  input logic         mem_ack,
  input logic         mem_err,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [31:0]  ip_out,
  input logic [31:0]  flags_out,
  input logic [255:0] gpr_out,
  input logic [111:0] sel_out,
  input logic [31:0]  ptb_out,
  input logic [15:0]  trap_out
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_wide));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ip_out) && $stable(flags_out) && $stable(gpr_out)
              && $stable(sel_out) && $stable(ptb_out) && $stable(trap_out));

  p_abort_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !done && !busy);

  p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> !mem_req);

  p_restart_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && start && !mem_ack && !mem_err |=> $stable(mem_addr));
endmodule

bind tss_loader tss_loader_chk u_tss_loader_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_wide(mem_wide), .mem_ack(mem_ack), .mem_err(mem_err), .busy(busy), .done(done),
  .fault(fault), .ip_out(ip_out), .flags_out(flags_out), .gpr_out(gpr_out),
  .sel_out(sel_out), .ptb_out(ptb_out), .trap_out(trap_out)
);

// File: tb/test_tss_loader.sv
module test_tss_loader;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, paging_en = 0;
  logic [31:0] seg_base = 0;
  logic [3:0]  desc_type = 0;
  logic mem_req, mem_wide, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic busy, done, fault;
  logic [31:0] ip_out, flags_out, ptb_out;
  logic [255:0] gpr_out;
  logic [111:0] sel_out;
  logic [15:0] trap_out;

  int checks = 0, errors = 0;
  int latency = 0, err_at = -1, nlog = 0, wait_cnt = 0;
  logic [31:0] log_addr [64];
  logic        log_wide [64];
  logic [31:0] prev_addr = 0;
  bit hold_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  tss_loader i_tss_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_base(seg_base), .desc_type(desc_type),
    .paging_en(paging_en), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wide(mem_wide),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fault(fault), .ip_out(ip_out), .flags_out(flags_out), .gpr_out(gpr_out),
    .sel_out(sel_out), .ptb_out(ptb_out), .trap_out(trap_out)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {~a[15:0] ^ 16'h0F0F, a[15:0] ^ 16'h3C5A};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      mem_ack = 0; mem_err = 0;
      if (mem_req) begin
        if (wait_cnt > 0 && mem_addr !== prev_addr) hold_bad = 1;
        prev_addr = mem_addr;
        if (wait_cnt < latency) wait_cnt++;
        else begin
          wait_cnt = 0;
          if (nlog < 64) begin log_addr[nlog] = mem_addr; log_wide[nlog] = mem_wide; end
          if (nlog == err_at) mem_err = 1;
          else begin mem_ack = 1; mem_rdata = memf(mem_addr); end
          nlog++;
        end
      end
    end
  end

  initial begin
    #(PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run(input logic [31:0] b, input logic [3:0] t, input bit pg, input int lat,
                     input int eidx, input bit poke, output bit got_done, output bit got_fault);
    logic [31:0] ip0;
    bit moved;
    moved = 0; got_done = 0; got_fault = 0;
    latency = lat; err_at = eidx; nlog = 0; wait_cnt = 0; hold_bad = 0;
    ip0 = ip_out;
    @(posedge clk); #1;
    seg_base = b; desc_type = t; paging_en = pg; start = 1;
    @(posedge clk); #1;
    start = 0; seg_base = 32'hDEAD_0000; desc_type = t ^ 4'h8; paging_en = !pg;
    @(negedge clk);
    chk(busy === 1'b1, "R10", "busy after start", 32'(busy), 1);
    for (int c = 0; c < 2000; c++) begin
      if (done || fault) break;
      if (ip_out !== ip0) moved = 1;
      if (poke && c == 4) start = 1;
      if (poke && c == 5) start = 0;
      @(negedge clk);
    end
    start = 0;
    got_done = done; got_fault = fault;
    chk(!moved, "R10", "outputs steady before done", 32'(moved), 0);
    chk(!hold_bad, "R8", "request held until answered", 32'(hold_bad), 0);
    @(negedge clk);
    chk(done === 1'b0 && fault === 1'b0, "R10", "single-cycle pulse", 32'({done, fault}), 0);
  endtask

  task automatic check16(input logic [31:0] b);
    bit ok;
    ok = (nlog == 15);
    for (int k = 0; k < 15; k++)
      if (log_addr[k] !== 32'(b + 32'(14 + 2*k)) || log_wide[k] !== 1'b0) ok = 0;
    chk(ok, "R1", "16-bit read stream", 32'(nlog), 15);
    chk(ip_out === {16'h0, memf(b + 32'd14)[15:0]}, "R2", "ip", ip_out, {16'h0, memf(b + 32'd14)[15:0]});
    chk(flags_out === {16'h0, memf(b + 32'd16)[15:0]}, "R2", "flags", flags_out, {16'h0, memf(b + 32'd16)[15:0]});
    for (int i = 0; i < 8; i++)
      chk(gpr_out[32*i +: 32] === {16'hFFFF, memf(b + 32'(18 + 2*i))[15:0]}, "R3", "gpr",
          gpr_out[32*i +: 32], {16'hFFFF, memf(b + 32'(18 + 2*i))[15:0]});
    for (int i = 0; i < 4; i++)
      chk(sel_out[16*i +: 16] === memf(b + 32'(34 + 2*i))[15:0], "R4", "selector",
          32'(sel_out[16*i +: 16]), 32'(memf(b + 32'(34 + 2*i))[15:0]));
    chk(sel_out[16*4 +: 32] === 32'h0, "R4", "FS/GS null", sel_out[16*4 +: 32], 0);
    chk(sel_out[16*6 +: 16] === memf(b + 32'd42)[15:0], "R4", "LDT", 32'(sel_out[16*6 +: 16]), 32'(memf(b + 32'd42)[15:0]));
    chk(ptb_out === 0 && trap_out === 0, "R4", "ptb/trap cleared", ptb_out | 32'(trap_out), 0);
  endtask

  task automatic check32(input logic [31:0] b, input bit pg);
    bit ok;
    int n, p;
    n = pg ? 19 : 18;
    p = 0; ok = (nlog == n);
    if (pg) begin
      if (log_addr[0] !== b + 32'h1C || log_wide[0] !== 1'b1) ok = 0;
      p = 1;
    end
    chk(ok, "R5", "page-base read presence", 32'(nlog), 32'(n));
    chk(ptb_out === (pg ? memf(b + 32'h1C) : 32'h0), "R5", "ptb", ptb_out, pg ? memf(b + 32'h1C) : 32'h0);
    ok = 1;
    for (int j = 0; j < 10; j++)
      if (log_addr[p + j] !== 32'(b + 32'(32'h20 + 4*j)) || log_wide[p + j] !== 1'b1) ok = 0;
    chk(ok, "R6", "4-byte read stream", 32'(ok), 1);
    chk(ip_out === memf(b + 32'h20), "R6", "ip", ip_out, memf(b + 32'h20));
    chk(flags_out === memf(b + 32'h24), "R6", "flags", flags_out, memf(b + 32'h24));
    for (int i = 0; i < 8; i++)
      chk(gpr_out[32*i +: 32] === memf(b + 32'(32'h28 + 4*i)), "R6", "gpr",
          gpr_out[32*i +: 32], memf(b + 32'(32'h28 + 4*i)));
    ok = 1;
    for (int j = 0; j < 8; j++)
      if (log_addr[p + 10 + j] !== 32'(b + 32'(32'h48 + 4*j)) || log_wide[p + 10 + j] !== 1'b0) ok = 0;
    chk(ok, "R7", "2-byte read stream", 32'(ok), 1);
    for (int i = 0; i < 7; i++)
      chk(sel_out[16*i +: 16] === memf(b + 32'(32'h48 + 4*i))[15:0], "R7", "selector",
          32'(sel_out[16*i +: 16]), 32'(memf(b + 32'(32'h48 + 4*i))[15:0]));
    chk(trap_out === memf(b + 32'h64)[15:0], "R7", "trap", 32'(trap_out), 32'(memf(b + 32'h64)[15:0]));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R10", "idle after reset", 32'({busy, done, fault, mem_req}), 0);
    chk(ip_out === 0 && gpr_out === 0 && sel_out === 0, "R10", "outputs cleared", ip_out, 0);
  endtask

  task automatic t_full32_paged;
    bit d, f;
    run(32'h0004_0100, 4'd9, 1, 1, -1, 0, d, f);
    chk(d && !f, "R5", "done with paging", 32'({d, f}), 2);
    check32(32'h0004_0100, 1);
  endtask

  task automatic t_full16;
    bit d, f;
    run(32'h0001_0000, 4'd1, 0, 0, -1, 0, d, f);
    chk(d && !f, "R1", "done 16-bit", 32'({d, f}), 2);
    check16(32'h0001_0000);
  endtask

  task automatic t_full32_flat;
    bit d, f;
    run(32'h0200_0040, 4'd4, 0, 0, -1, 0, d, f);
    chk(d && !f, "R5", "done without paging", 32'({d, f}), 2);
    check32(32'h0200_0040, 0);
  endtask

  task automatic t_wrap16;
    bit d, f;
    run(32'hFFFF_FFF0, 4'd3, 1, 2, -1, 0, d, f);
    chk(d && !f, "R8", "done across wrap", 32'({d, f}), 2);
    chk(log_addr[14] === 32'h0000_001A, "R8", "wrapped address", log_addr[14], 32'h1A);
    check16(32'hFFFF_FFF0);
  endtask

  task automatic t_restart_busy;
    bit d, f;
    run(32'h0030_0000, 4'd11, 1, 3, -1, 1, d, f);
    chk(d && !f, "R11", "original run completes", 32'({d, f}), 2);
    check32(32'h0030_0000, 1);
    repeat (6) @(negedge clk);
    chk(!busy && nlog == 19, "R11", "no second sequence", 32'(nlog), 19);
  endtask

  task automatic t_abort;
    bit d, f;
    logic [31:0] ip0, pb0;
    logic [255:0] g0;
    logic [111:0] s0;
    ip0 = ip_out; pb0 = ptb_out; g0 = gpr_out; s0 = sel_out;
    run(32'h0777_0000, 4'd9, 1, 1, 5, 0, d, f);
    chk(f && !d, "R9", "fault without done", 32'({d, f}), 1);
    chk(ip_out === ip0 && ptb_out === pb0 && gpr_out === g0 && sel_out === s0, "R9",
        "outputs unchanged", ip_out, ip0);
    repeat (4) @(negedge clk);
    chk(nlog == 6 && !busy && !mem_req, "R9", "no reads after error", 32'(nlog), 6);
  endtask

  task automatic t_recover;
    bit d, f;
    run(32'h0000_8000, 4'd2, 0, 1, -1, 0, d, f);
    chk(d && !f, "R9", "load after abort", 32'({d, f}), 2);
    check16(32'h0000_8000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_full32_paged;
    t_full16;
    t_full32_flat;
    t_wrap16;
    t_restart_busy;
    t_abort;
    t_recover;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule